// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory. A request carries the linear address, a write flag and a user flag. Alongside it the block samples the page-table root, the paging enable, the supervisor write-protect enable, the large-page enable and the A20 gate. The root and the paging enable are used in the acceptance cycle to start the walk. The write-protect enable, the large-page enable and the A20 gate are held for the rest of the walk. The walker reads the directory entry and then, unless the entry maps a 4 MB page, the table entry. It merges the permission bits of both levels and checks them against the access. It writes the accessed and dirty bits back into memory by read-modify-write. It then reports either a physical address with read and write grants, or a page-fault code.

Memory is reached through a single request/acknowledge port that carries one 32-bit word per transfer. Only one walk runs at a time. The result is meant to fill a translation cache that lives outside this block. The write grant is given only for pages that are already dirty, so the first write to a clean page comes back through the walker and sets the dirty bit.

Entry bit positions, used by both levels: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 7 large page (directory only). Fault code: bit 0 set for a protection fault and clear for a not-present fault, bit 1 equal to the write flag, bit 2 equal to the user flag.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, fault and mem_req are low.
- R2: With paging disabled, done pulses two cycles after acceptance. The physical address is the linear address with the A20 mask applied, write is granted, large is 0, and no memory transfer is made.
- R3: The first transfer of a walk is a read of address (root with bits 11:0 cleared) + 4 * linear[31:22]. For a 4 KB page the table-entry read follows it, at (directory entry with bits 11:0 cleared) + 4 * linear[21:12].
- R4: If bit 0 of the directory or table entry is clear, the walk ends with a fault pulse and a code of {user, write, 0}, and the table entry is not written.
- R5: A directory entry with bit 7 set maps a 4 MB page only when the large-page enable is high. The physical address is then {entry[31:22], linear[21:0]} and rsp_large is 1. When the enable is low, bit 7 is ignored and the table level is walked.
- R6: The effective user bit and the effective writable bit are the AND of that bit over both levels (the directory alone for a 4 MB page). A user access faults if user is 0, and a user write faults if writable is 0. A supervisor write faults only if write-protect is on and writable is 0. A protection fault gives code {user, write, 1} and writes nothing to the final entry.
- R7: On a 4 KB walk, the directory entry is written back with bit 5 set, before the table read, only when bit 5 was clear.
- R8: The final entry gets bit 5 and, on a write, bit 6. It is written back once, after the last read, only when its value changes.
- R9: rsp_wr is 1 only if the final entry is dirty after the update and either the effective writable bit is 1, or the access is supervisor with write-protect off. rsp_rd is 1 on every done pulse.
- R10: When the A20 gate is closed, bit 20 is cleared in every memory address and in the returned physical address.
- R11: busy is high from acceptance until the cycle in which done or fault pulses, and requests while busy are ignored. Each accepted request yields exactly one pulse, on done or on fault.
- R12: mem_addr, mem_we and mem_wdata stay stable while mem_req is high and mem_ack has not arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, accepted when busy is low |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| busy | output | 1 | Walk in progress |
| cfg_root | input | 32 | Page-table root address |
| cfg_paging_en | input | 1 | Paging enabled |
| cfg_wp_en | input | 1 | Supervisor write-protect enabled |
| cfg_large_en | input | 1 | 4 MB pages enabled |
| cfg_a20_open | input | 1 | A20 gate open (bit 20 passes) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Transfer byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: page fault |
| rsp_paddr | output | 32 | Physical address, valid with done |
| rsp_rd | output | 1 | Read granted, valid with done |
| rsp_wr | output | 1 | Write granted, valid with done |
| rsp_large | output | 1 | Result came from a 4 MB page |
| fault_code | output | 3 | Page-fault code, valid with fault |

## Verification
The completion pulse of a walk and the acceptance of a new request can meet in the same cycle. The edge that raises done or fault is also the last edge at which busy is still high. The bench holds req_valid high with a different address for the whole walk, including that final edge, and drops it only once busy reads low. It then requires exactly one response, with the first address's translation, and an empty scoreboard. Memory wait states are added on part of the walks to show that a held transfer request stays unchanged until it is acknowledged.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Entry field positions shared by both table levels.
  localparam int unsigned ENT_P  = 0;
  localparam int unsigned ENT_RW = 1;
  localparam int unsigned ENT_US = 2;
  localparam int unsigned ENT_A  = 5;
  localparam int unsigned ENT_D  = 6;
  localparam int unsigned ENT_PS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_DIR,
    ST_DIR_WB,
    ST_TBL,
    ST_FIN_WB
  } walk_state_e;

  // Result of a returned directory/table read.
  typedef enum logic [2:0] {
    OC_NONE,
    OC_MISS,
    OC_DENY,
    OC_HIT,
    OC_DESCEND
  } walk_outcome_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } pf_code_t;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10
) (
  input  logic [ADDR_W-1:0] root,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] va_q,
  input  logic [ADDR_W-1:0] dir_e,
  input  logic [ADDR_W-1:0] fin_e,
  input  logic              is_large,
  input  logic [ADDR_W-1:0] mask_now,
  input  logic [ADDR_W-1:0] mask_q,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] paddr
);
  localparam int LARGE_BITS = PAGE_BITS + IDX_BITS;
  localparam logic [ADDR_W-1:0] PG_LOW  = (ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LG_LOW  = (ADDR_W'(1) << LARGE_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_MSK = (ADDR_W'(1) << IDX_BITS) - ADDR_W'(1);

  logic [ADDR_W-1:0] dir_off, tbl_off, small_pa, large_pa;

  always_comb begin
    dir_off  = (req_va >> LARGE_BITS) << 2;
    tbl_off  = ((va_q >> PAGE_BITS) & IDX_MSK) << 2;
    dir_addr = ((root & ~PG_LOW) + dir_off) & mask_now;
    tbl_addr = ((dir_e & ~PG_LOW) + tbl_off) & mask_q;
    small_pa = (fin_e & ~PG_LOW) | (va_q & PG_LOW);
    large_pa = (fin_e & ~LG_LOW) | (va_q & LG_LOW);
    paddr    = (is_large ? large_pa : small_pa) & mask_q;
  end
endmodule

// File: rtl/pt_walk_perm.sv
module pt_walk_perm
  import pt_walker_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] dir_e,
  input  logic [ENT_W-1:0] tbl_e,
  input  logic             is_large,
  input  logic             acc_write,
  input  logic             acc_user,
  input  logic             wp_en,
  output logic             prot_fault,
  output logic [ENT_W-1:0] fin_new,
  output logic             fin_changed,
  output logic             wr_grant
);
  logic [ENT_W-1:0] fin_old;
  logic eff_us, eff_rw;

  always_comb begin
    fin_old = is_large ? dir_e : tbl_e;
    eff_us  = dir_e[ENT_US] & (is_large | tbl_e[ENT_US]);
    eff_rw  = dir_e[ENT_RW] & (is_large | tbl_e[ENT_RW]);
    if (acc_user) prot_fault = !eff_us || (acc_write && !eff_rw);
    else          prot_fault = acc_write && wp_en && !eff_rw;
    fin_new     = fin_old | (ENT_W'(1) << ENT_A) | (ENT_W'(acc_write) << ENT_D);
    fin_changed = (fin_new != fin_old);
    wr_grant    = fin_new[ENT_D] && (eff_rw || (!acc_user && !wp_en));
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10,
  parameter int A20_BIT   = 20,
  parameter bit A20_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              busy,
  input  logic [ADDR_W-1:0] cfg_root,
  input  logic              cfg_paging_en,
  input  logic              cfg_wp_en,
  input  logic              cfg_large_en,
  input  logic              cfg_a20_open,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_large,
  output logic [2:0]        fault_code
);
  localparam logic [ADDR_W-1:0] A20_M = ADDR_W'(1) << A20_BIT;

  walk_state_e   state;
  walk_outcome_e outcome;

  logic [ADDR_W-1:0] va_q, dir_q, dir_cur;
  logic              wr_q, us_q, wp_q, lg_q, a20_q;
  logic [ADDR_W-1:0] mask_now, mask_q;
  logic [ADDR_W-1:0] dir_addr, tbl_addr, paddr, fin_new;
  logic              is_large_now, prot_fault, fin_changed, wr_grant;

  // Gate variant picked by parameter.
  generate
    if (A20_EN) begin : g_a20
      assign mask_now = ~A20_M | (cfg_a20_open ? A20_M : '0);
      assign mask_q   = ~A20_M | (a20_q ? A20_M : '0);
    end else begin : g_noa20
      assign mask_now = '1;
      assign mask_q   = '1;
    end
  endgenerate

  assign dir_cur      = (state == ST_DIR) ? mem_rdata : dir_q;
  assign is_large_now = (state == ST_DIR) && mem_rdata[ENT_PS] && lg_q;

  pt_walk_addr #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .IDX_BITS (IDX_BITS)
  ) u_addr (
    .root    (cfg_root),
    .req_va  (req_vaddr),
    .va_q    (va_q),
    .dir_e   (dir_cur),
    .fin_e   (mem_rdata),
    .is_large(is_large_now),
    .mask_now(mask_now),
    .mask_q  (mask_q),
    .dir_addr(dir_addr),
    .tbl_addr(tbl_addr),
    .paddr   (paddr)
  );

  pt_walk_perm #(
    .ENT_W(ADDR_W)
  ) u_perm (
    .dir_e      (dir_cur),
    .tbl_e      (mem_rdata),
    .is_large   (is_large_now),
    .acc_write  (wr_q),
    .acc_user   (us_q),
    .wp_en      (wp_q),
    .prot_fault (prot_fault),
    .fin_new    (fin_new),
    .fin_changed(fin_changed),
    .wr_grant   (wr_grant)
  );

  always_comb begin
    outcome = OC_NONE;
    if ((state == ST_DIR || state == ST_TBL) && mem_ack) begin
      if (!mem_rdata[ENT_P])
        outcome = OC_MISS;
      else if (state == ST_TBL || is_large_now)
        outcome = prot_fault ? OC_DENY : OC_HIT;
      else
        outcome = OC_DESCEND;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rsp_paddr  <= '0;
      rsp_rd     <= 1'b0;
      rsp_wr     <= 1'b0;
      rsp_large  <= 1'b0;
      va_q       <= '0;
      dir_q      <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      wp_q       <= 1'b0;
      lg_q       <= 1'b0;
      a20_q      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            busy  <= 1'b1;
            va_q  <= req_vaddr;
            wr_q  <= req_write;
            us_q  <= req_user;
            wp_q  <= cfg_wp_en;
            lg_q  <= cfg_large_en;
            a20_q <= cfg_a20_open;
            if (!cfg_paging_en) begin
              rsp_paddr <= req_vaddr & mask_now;
              rsp_rd    <= 1'b1;
              rsp_wr    <= 1'b1;
              rsp_large <= 1'b0;
              state     <= ST_PASS;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_addr;
              state    <= ST_DIR;
            end
          end
        end
        ST_PASS: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_DIR_WB: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= tbl_addr;
            state    <= ST_TBL;
          end
        end
        ST_FIN_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: begin
          // ST_DIR and ST_TBL: act on the returned entry.
          if (state == ST_DIR && mem_ack) dir_q <= mem_rdata;
          unique case (outcome)
            OC_MISS, OC_DENY: begin
              mem_req    <= 1'b0;
              fault      <= 1'b1;
              busy       <= 1'b0;
              fault_code <= pf_code_t'({us_q, wr_q, outcome == OC_DENY});
              state      <= ST_IDLE;
            end
            OC_HIT: begin
              rsp_paddr <= paddr;
              rsp_rd    <= 1'b1;
              rsp_wr    <= wr_grant;
              rsp_large <= is_large_now;
              if (fin_changed) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_wdata <= fin_new;
                state     <= ST_FIN_WB;
              end else begin
                mem_req <= 1'b0;
                done    <= 1'b1;
                busy    <= 1'b0;
                state   <= ST_IDLE;
              end
            end
            OC_DESCEND: begin
              if (!mem_rdata[ENT_A]) begin
                mem_we    <= 1'b1;
                mem_wdata <= mem_rdata | (ADDR_W'(1) << ENT_A);
                state     <= ST_DIR_WB;
              end else begin
                mem_we   <= 1'b0;
                mem_addr <= tbl_addr;
                state    <= ST_TBL;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W  = 32,
  parameter int A20_BIT = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              pa_a20,
  input logic [2:0]        fault_code,
  input logic              a20_q,
  input logic              wr_q,
  input logic              us_q
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !fault && !mem_req));

  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_pulse_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> ($past(busy) && !busy));

  assert_no_mem_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_addr_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !a20_q) |-> !mem_addr[A20_BIT]);

  assert_pa_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !a20_q) |-> !pa_a20);

  assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[5]);

  assert_code_flags_R4: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_code[2:1] == {us_q, wr_q}));

  assert_code_held_R4: assert property (@(posedge clk) disable iff (rst)
    !fault |-> $stable(fault_code));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .A20_BIT(A20_BIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pa_a20    (rsp_paddr[A20_BIT]),
  .fault_code(fault_code),
  .a20_q     (a20_q),
  .wr_q      (wr_q),
  .us_q      (us_q)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = 0;
  logic [31:0] cfg_root = 32'h1000;
  logic        cfg_paging_en = 1, cfg_wp_en = 0, cfg_large_en = 0, cfg_a20_open = 1;
  logic        busy, mem_req, mem_we, mem_ack, done, fault, rsp_rd, rsp_wr, rsp_large;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_paddr;
  logic [2:0]  fault_code;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .busy(busy), .cfg_root(cfg_root),
    .cfg_paging_en(cfg_paging_en), .cfg_wp_en(cfg_wp_en), .cfg_large_en(cfg_large_en),
    .cfg_a20_open(cfg_a20_open), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .fault(fault), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_large(rsp_large), .fault_code(fault_code)
  );

  int checks = 0, failures = 0, n_rd = 0, n_wr = 0, n_resp = 0, lat = 0;
  bit finished = 0;
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] op_log[$];

  typedef struct {
    string       tag;
    bit          is_fault;
    logic [2:0]  code;
    logic [31:0] pa;
    logic        wr;
    logic        lg;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder with optional wait states.
  initial begin
    mem_ack = 0;
    mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        logic [31:0] cap;
        cap = mem_addr;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk("R12 address held during wait", mem_addr, cap);
        end
        op_log.push_back({mem_addr[31:1], mem_we});
        if (mem_we) begin
          mem_m[mem_addr] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
          n_rd++;
        end
        mem_ack = 1;
      end
    end
  end

  // Monitor: pops the scoreboard on every response pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (done || fault)) begin
        n_resp++;
        if (sb_q.size() == 0) chk("R11 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.tag, " kind"}, fault, e.is_fault);
          if (e.is_fault) chk({e.tag, " code"}, fault_code, e.code);
          else begin
            chk({e.tag, " paddr"}, rsp_paddr, e.pa);
            chk({e.tag, " wr"}, rsp_wr, e.wr);
            chk({e.tag, " large"}, rsp_large, e.lg);
            chk({e.tag, " R9 rd"}, rsp_rd, 1);
          end
        end
      end
    end
  end

  task automatic push(input string tag, input bit f, input logic [2:0] c,
                      input logic [31:0] pa, input logic wr, input logic lg);
    exp_t e;
    e.tag = tag; e.is_fault = f; e.code = c; e.pa = pa; e.wr = wr; e.lg = lg;
    sb_q.push_back(e);
  endtask

  task automatic walk(input logic [31:0] va, input logic w, input logic u, input bit stray);
    @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1;
    @(negedge clk);
    if (stray) req_vaddr = 32'hFFFF_F000;
    else req_valid = 0;
    do @(negedge clk); while (busy);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic ok(input string tag, input logic [31:0] va, input logic w, input logic u,
                    input logic [31:0] pa, input logic wr, input logic lg);
    push(tag, 0, 0, pa, wr, lg);
    walk(va, w, u, 0);
  endtask

  task automatic bad(input string tag, input logic [31:0] va, input logic w, input logic u,
                     input logic [2:0] c);
    push(tag, 1, c, 0, 0, 0);
    walk(va, w, u, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w0, r0, q0;
    mem_m[32'h1004] = 32'h0000_2007;
    mem_m[32'h200C] = 32'h0005_5007;
    mem_m[32'h100C] = 32'h0000_3027;
    mem_m[32'h1010] = 32'h0000_4023;
    mem_m[32'h4000] = 32'h0006_0067;
    mem_m[32'h1014] = 32'h0000_5027;
    mem_m[32'h5000] = 32'h0007_0065;
    mem_m[32'h1018] = 32'h0C00_0087;
    mem_m[32'h0C00_048C] = 32'h0008_8067;
    mem_m[32'h101C] = 32'h0000_2027;
    mem_m[32'h2014] = 32'h0013_4067;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done/fault after reset", {done, fault}, 0);

    // R2 paging off
    cfg_paging_en = 0;
    r0 = n_rd + n_wr;
    ok("R2 identity", 32'h1234_5678, 1, 1, 32'h1234_5678, 1, 0);
    cfg_a20_open = 0;
    ok("R2 R10 identity gated", 32'h0017_0ABC, 0, 0, 32'h0007_0ABC, 1, 0);
    chk("R2 no memory transfer", n_rd + n_wr, r0);
    cfg_a20_open = 1;
    cfg_paging_en = 1;

    // 4 KB page, clean, with wait states: both accessed write-backs
    lat = 2;
    op_log.delete();
    w0 = n_wr;
    ok("R3 R12 clean read", 32'h0040_3123, 0, 1, 32'h0005_5123, 0, 0);
    chk("R7 R8 two write-backs", n_wr - w0, 2);
    chk("R3 op count", op_log.size(), 4);
    if (op_log.size() == 4) begin
      chk("R3 dir read addr", op_log[0], 32'h1004);
      chk("R7 dir write before table", op_log[1], 32'h1005);
      chk("R3 table read addr", op_log[2], 32'h200C);
      chk("R8 table write", op_log[3], 32'h200D);
    end
    chk("R7 dir accessed set", mem_m[32'h1004], 32'h0000_2027);
    chk("R8 table accessed only", mem_m[32'h200C], 32'h0005_5027);
    lat = 0;

    w0 = n_wr;
    ok("R9 write sets dirty", 32'h0040_3123, 1, 1, 32'h0005_5123, 1, 0);
    chk("R7 R8 only table written", n_wr - w0, 1);
    chk("R8 table dirty", mem_m[32'h200C], 32'h0005_5067);
    w0 = n_wr;
    ok("R9 dirty read writable", 32'h0040_3123, 0, 1, 32'h0005_5123, 1, 0);
    chk("R8 unchanged no write", n_wr - w0, 0);

    // Not present
    bad("R4 dir missing", 32'h0080_0010, 1, 1, 3'b110);
    w0 = n_wr;
    bad("R4 table missing", 32'h00C0_0000, 0, 0, 3'b000);
    chk("R4 no write on miss", n_wr - w0, 0);

    // Protection
    w0 = n_wr;
    bad("R6 dir user clear", 32'h0100_0000, 0, 1, 3'b101);
    chk("R6 no write on deny", n_wr - w0, 0);
    ok("R6 supervisor passes", 32'h0100_0000, 0, 0, 32'h0006_0000, 1, 0);
    bad("R6 user write ro", 32'h0140_0234, 1, 1, 3'b111);
    ok("R9 user read ro", 32'h0140_0234, 0, 1, 32'h0007_0234, 0, 0);
    cfg_wp_en = 1;
    bad("R6 sup write wp", 32'h0140_0234, 1, 0, 3'b011);
    ok("R9 sup read wp ro", 32'h0140_0234, 0, 0, 32'h0007_0234, 0, 0);
    cfg_wp_en = 0;
    ok("R6 R9 sup write no wp", 32'h0140_0234, 1, 0, 32'h0007_0234, 1, 0);

    // Large pages
    cfg_large_en = 1;
    w0 = n_wr;
    ok("R5 large write", 32'h0192_3456, 1, 1, 32'h0C12_3456, 1, 1);
    chk("R8 large dir updated", mem_m[32'h1018], 32'h0C00_00E7);
    chk("R8 one write", n_wr - w0, 1);
    cfg_large_en = 0;
    ok("R5 bit7 ignored", 32'h0192_3456, 0, 1, 32'h0008_8456, 1, 0);

    // A20
    cfg_a20_open = 0;
    cfg_root = 32'h0010_1000;
    ok("R10 gated walk", 32'h01C0_50AB, 0, 1, 32'h0003_40AB, 1, 0);
    cfg_a20_open = 1;
    bad("R10 open root misses", 32'h01C0_50AB, 0, 1, 3'b100);
    cfg_root = 32'h0000_1000;
    ok("R10 open walk", 32'h01C0_50AB, 0, 1, 32'h0013_40AB, 1, 0);

    // Request held through completion edge
    q0 = n_resp;
    push("R11 stray ignored", 0, 0, 32'h0005_5123, 1, 0);
    walk(32'h0040_3123, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk("R11 one response", n_resp - q0, 1);
    chk("R11 scoreboard empty", sb_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule